// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter units for a small microcontroller. Each unit has a low and a high count byte. A shared configuration byte and a shared control byte set the units up, and the CPU can read and write all of them through one byte-wide register port. A unit counts either machine cycles or falling edges on its own external count pin. A unit can also be gated by an external level pin. When its count wraps, the unit raises an overflow flag, and that flag stays raised until software clears it.

A machine cycle is `PRESCALE` input clocks long, 12 by default. Each unit runs in one of four modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, or split mode. In split mode, unit 0's two bytes become two independent 8-bit timers. The second of those timers takes over unit 1's run bit and unit 1's overflow flag.

Top module: `tmrpair`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow outputs are low. The registers are: count bytes at addresses 0 (unit 0 low), 1 (unit 0 high), 2 (unit 1 low) and 3 (unit 1 high); the configuration byte at address 4; the control byte at address 5. Addresses 6 and 7 read 0x00.
- R2: The configuration byte holds one nibble per unit, unit 0 in bits [3:0] and unit 1 in bits [7:4]. Within a nibble, [1:0] is the mode (00 13-bit, 01 16-bit, 10 reload, 11 split), bit 2 selects pin counting and bit 3 is the gate enable. In timer mode, a running unit advances exactly once per `PRESCALE` clocks, and a unit whose run bit is clear holds its count. The control byte holds run 0 in bit 0, run 1 in bit 1, flag 0 in bit 2 and flag 1 in bit 3.
- R3: In 13-bit mode, the count is {high byte, low byte bits [4:0]}. Bits [7:5] of the low byte keep their value. The flag sets when all 13 bits wrap to zero.
- R4: In 16-bit mode, {high, low} increments as one value, and the flag sets on the wrap from 0xFFFF to 0x0000.
- R5: In reload mode, the low byte counts up. On the step after 0xFF, it takes the high byte's value and the flag sets. The high byte is unchanged.
- R6: When unit 0 is in split mode, unit 0's low byte is an 8-bit timer driven by unit 0's run, gate and select bits, and it sets flag 0. Unit 0's high byte is an 8-bit machine-cycle timer driven only by run 1, and it sets flag 1.
- R7: Unit 1 in mode 11 holds its count. While unit 0 is split, unit 1 in any other mode counts regardless of run 1 and never sets flag 1.
- R8: With the select bit set, a unit advances once per falling edge on its count pin. A falling edge is a high sample at one machine-cycle tick followed by a low sample at the next. A static pin level causes no counting.
- R9: With the gate bit set, a running unit advances only while its gate pin is high. With the gate bit clear, the gate pin has no effect.
- R10: A flag stays set until software writes 0 to its control bit. Writing 1 to the bit sets it. A hardware set wins over a clear written in the same cycle.
- R11: A write to a count byte in a cycle where the unit would also advance stores the written value, and that unit's count step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| ext_cnt | input | 2 | Count pins, one per unit |
| ext_gate | input | 2 | Gate level pins, one per unit |
| ovf | output | 2 | Overflow flags, one per unit |

## Verification
The bench builds the block with `PRESCALE` = 3. Over any run of 3·k consecutive clocks, a running timer then advances by exactly k, whatever the phase of the prescaler. This lets the bench predict every count without seeing the tick. With machine cycles that short, the bench can step through complete 13-bit, 16-bit and reload wrap sequences one tick at a time and compare each step with arithmetic it does itself. It can also sweep a write across every prescaler phase to show that a write always wins over a count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_13    = 2'b00,
        MODE_16    = 2'b01,
        MODE_RLD   = 2'b10,
        MODE_SPLIT = 2'b11
    } tmr_mode_e;

    // One configuration nibble: gate enable, pin-count select, mode.
    typedef struct packed {
        logic      gate;
        logic      pin_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;

    // Result of one count step on a byte pair.
    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic       wrap;
    } tmr_step_t;

    localparam logic [2:0] A_LO0 = 3'd0;
    localparam logic [2:0] A_HI0 = 3'd1;
    localparam logic [2:0] A_LO1 = 3'd2;
    localparam logic [2:0] A_HI1 = 3'd3;
    localparam logic [2:0] A_CFG = 3'd4;
    localparam logic [2:0] A_CTL = 3'd5;

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int PRESCALE = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (PRESCALE > 1) begin : g_spaced
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic [N-1:0] smp;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    smp[i] <= 1'b0;
                end else if (tick) begin
                    smp[i] <= pin[i];
                end
            end
            assign fall[i] = tick & smp[i] & ~pin[i];

            // R8
            fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fall[i] |-> tick);
        end
    endgenerate

endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pkg::*;
(
    input  tmr_mode_e  mode,
    input  logic [7:0] lo,
    input  logic [7:0] hi,
    input  logic       inc,
    output tmr_step_t  nxt
);
    logic [5:0]  sum5;
    logic [16:0] sum16;
    logic [8:0]  sum8;

    assign sum5  = {1'b0, lo[4:0]} + 6'd1;
    assign sum16 = {1'b0, hi, lo} + 17'd1;
    assign sum8  = {1'b0, lo} + 9'd1;

    always_comb begin
        nxt.lo   = lo;
        nxt.hi   = hi;
        nxt.wrap = 1'b0;
        if (inc) begin
            unique case (mode)
                MODE_13: begin
                    nxt.lo = {lo[7:5], sum5[4:0]};
                    if (sum5[5]) begin
                        nxt.hi   = hi + 8'd1;
                        nxt.wrap = (hi == 8'hFF);
                    end
                end
                MODE_16: begin
                    nxt.lo   = sum16[7:0];
                    nxt.hi   = sum16[15:8];
                    nxt.wrap = sum16[16];
                end
                MODE_RLD: begin
                    if (lo == 8'hFF) begin
                        nxt.lo   = hi;
                        nxt.wrap = 1'b1;
                    end else begin
                        nxt.lo = sum8[7:0];
                    end
                end
                MODE_SPLIT: begin
                    nxt.lo   = sum8[7:0];
                    nxt.wrap = sum8[8];
                end
            endcase
        end
    end

endmodule

// File: rtl/tmrpair.sv
module tmrpair
    import tmr_pkg::*;
#(
    parameter int PRESCALE = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic [1:0] ext_cnt,
    input  logic [1:0] ext_gate,
    output logic [1:0] ovf
);
    localparam int NU = 2;

    logic          tick;
    logic [NU-1:0] fall;

    logic [7:0] lo0, hi0, lo1, hi1;
    tmr_cfg_t   cfg0, cfg1;
    logic [1:0] run;
    logic [1:0] flag;

    tmr_step_t  st0, st1;
    logic       split0;
    logic       ev0, ev1, ev_hi0;
    logic       hit_lo0, hit_hi0, hit_lo1, hit_hi1, hit_cfg, hit_ctl;
    logic       set0, set1, hi0_wrap;

    tmr_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tmr_edge #(.N(NU)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pin   (ext_cnt),
        .fall  (fall)
    );

    // Count enables
    assign split0 = (cfg0.mode == MODE_SPLIT);
    assign ev0    = (cfg0.pin_sel ? fall[0] : tick) & run[0]
                    & (~cfg0.gate | ext_gate[0]);
    assign ev1    = (cfg1.pin_sel ? fall[1] : tick) & (run[1] | split0)
                    & (~cfg1.gate | ext_gate[1]) & (cfg1.mode != MODE_SPLIT);
    assign ev_hi0 = tick & run[1] & split0;

    tmr_step u_step0 (.mode(cfg0.mode), .lo(lo0), .hi(hi0), .inc(ev0), .nxt(st0));
    tmr_step u_step1 (.mode(cfg1.mode), .lo(lo1), .hi(hi1), .inc(ev1), .nxt(st1));

    // Register decode
    assign hit_lo0 = wr_en & (addr == A_LO0);
    assign hit_hi0 = wr_en & (addr == A_HI0);
    assign hit_lo1 = wr_en & (addr == A_LO1);
    assign hit_hi1 = wr_en & (addr == A_HI1);
    assign hit_cfg = wr_en & (addr == A_CFG);
    assign hit_ctl = wr_en & (addr == A_CTL);

    assign hi0_wrap = ev_hi0 & (hi0 == 8'hFF) & ~hit_hi0;
    assign set0 = split0 ? (st0.wrap & ~hit_lo0) : (st0.wrap & ~hit_lo0 & ~hit_hi0);
    assign set1 = split0 ? hi0_wrap : (st1.wrap & ~hit_lo1 & ~hit_hi1);

    // Unit 0 count bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo0 <= '0;
            hi0 <= '0;
        end else if (split0) begin
            lo0 <= hit_lo0 ? wr_data : st0.lo;
            if (hit_hi0) begin
                hi0 <= wr_data;
            end else if (ev_hi0) begin
                hi0 <= hi0 + 8'd1;
            end
        end else if (hit_lo0 | hit_hi0) begin
            if (hit_lo0) lo0 <= wr_data;
            if (hit_hi0) hi0 <= wr_data;
        end else begin
            lo0 <= st0.lo;
            hi0 <= st0.hi;
        end
    end

    // Unit 1 count bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo1 <= '0;
            hi1 <= '0;
        end else if (hit_lo1 | hit_hi1) begin
            if (hit_lo1) lo1 <= wr_data;
            if (hit_hi1) hi1 <= wr_data;
        end else begin
            lo1 <= st1.lo;
            hi1 <= st1.hi;
        end
    end

    // Configuration, run bits and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg0 <= tmr_cfg_t'(4'h0);
            cfg1 <= tmr_cfg_t'(4'h0);
            run  <= '0;
            flag <= '0;
        end else begin
            if (hit_cfg) begin
                cfg0 <= tmr_cfg_t'(wr_data[3:0]);
                cfg1 <= tmr_cfg_t'(wr_data[7:4]);
            end
            if (hit_ctl) begin
                run <= wr_data[1:0];
            end
            flag[0] <= set0 | (hit_ctl ? wr_data[2] : flag[0]);
            flag[1] <= set1 | (hit_ctl ? wr_data[3] : flag[1]);
        end
    end

    assign ovf = flag;

    always_comb begin
        unique case (addr)
            A_LO0:   rd_data = lo0;
            A_HI0:   rd_data = hi0;
            A_LO1:   rd_data = lo1;
            A_HI1:   rd_data = hi1;
            A_CFG:   rd_data = {cfg1, cfg0};
            A_CTL:   rd_data = {4'b0000, flag, run};
            default: rd_data = 8'h00;
        endcase
    end

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1)));

    // R10
    flag0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[0] && !hit_ctl) |=> flag[0]);

    // R10
    flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[1] && !hit_ctl) |=> flag[1]);

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0.mode == MODE_RLD && ev0 && lo0 == 8'hFF && !hit_lo0 && !hit_hi0)
        |=> (lo0 == $past(hi0) && flag[0]));

    // R7
    unit1_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg1.mode == MODE_SPLIT && !wr_en) |=> ($stable(lo1) && $stable(hi1)));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo1 |=> (lo1 == $past(wr_data)));

endmodule

// File: tb/tmrpair_tb.sv
module tmrpair_tb;
    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [1:0] ext_cnt = 2'b00;
    logic [1:0] ext_gate = 2'b00;
    logic [1:0] ovf;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmrpair #(.PRESCALE(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ext_cnt(ext_cnt), .ext_gate(ext_gate), .ovf(ovf)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, b, c;
        logic [12:0] v13;
        logic [15:0] v16;
        logic [7:0] rl;
        logic fl;

        waitc(3);
        rst_n = 1'b1;
        waitc(1);

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), a);
            check("R1 reset register", a, 0);
        end
        check("R1 reset flags", ovf, 0);

        // R2 halted then rate
        wr(3'd4, 8'h01);
        waitc(5 * P);
        rd(3'd0, a);
        check("R2 halted count", a, 0);
        wr(3'd5, 8'h01);
        for (int k = 1; k <= 4; k++) begin
            rd(3'd0, a);
            waitc(k * P);
            rd(3'd0, b);
            check("R2 rate window", 8'(b - a), k);
        end

        // R3 13-bit sweep across the wrap
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hB0);
        wr(3'd1, 8'hFF);
        wr(3'd5, 8'h01);
        v13 = 13'h1FF0;
        fl = 1'b0;
        for (int i = 1; i <= 24; i++) begin
            waitc(P);
            v13 = v13 + 13'd1;
            if (v13 == 13'd0) fl = 1'b1;
            rd(3'd0, a);
            rd(3'd1, b);
            check("R3 13-bit step", {ovf[0], b, a}, {fl, v13[12:5], 3'b101, v13[4:0]});
        end

        // R4 16-bit sweep on unit 1
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h10);
        wr(3'd2, 8'hF8);
        wr(3'd3, 8'hFF);
        wr(3'd5, 8'h02);
        v16 = 16'hFFF8;
        fl = 1'b0;
        for (int i = 1; i <= 14; i++) begin
            waitc(P);
            v16 = v16 + 16'd1;
            if (v16 == 16'd0) fl = 1'b1;
            rd(3'd2, a);
            rd(3'd3, b);
            check("R4 16-bit step", {ovf[1], b, a}, {fl, v16});
        end

        // R5 reload sweep on unit 0
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h02);
        wr(3'd1, 8'hFC);
        wr(3'd0, 8'hFA);
        wr(3'd5, 8'h01);
        rl = 8'hFA;
        fl = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            waitc(P);
            if (rl == 8'hFF) begin
                rl = 8'hFC;
                fl = 1'b1;
            end else begin
                rl = rl + 8'd1;
            end
            rd(3'd0, a);
            rd(3'd1, b);
            check("R5 reload step", {ovf[0], b, a}, {fl, 8'hFC, rl});
        end

        // R10 flag sticky, cleared only by writing 0
        wr(3'd5, 8'h04);
        waitc(4 * P);
        check("R10 flag held while stopped", ovf, 2'b01);
        wr(3'd5, 8'h00);
        check("R10 flag cleared", ovf, 2'b00);
        wr(3'd5, 8'h08);
        check("R10 flag set by write", ovf, 2'b10);
        wr(3'd5, 8'h00);

        // R6 split mode, R7 unit 1 stopped in mode 11
        wr(3'd4, 8'h33);
        wr(3'd0, 8'hFD);
        wr(3'd1, 8'hFA);
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h50);
        wr(3'd5, 8'h03);
        waitc(3 * P);
        rd(3'd0, a);
        rd(3'd1, b);
        check("R6 split low wrap", {ovf, b, a}, {2'b01, 8'hFD, 8'h00});
        waitc(3 * P);
        rd(3'd0, a);
        rd(3'd1, b);
        check("R6 split high wrap", {ovf, b, a}, {2'b11, 8'h00, 8'h03});
        rd(3'd2, a);
        rd(3'd3, b);
        check("R7 unit 1 held in mode 11", {b, a}, 16'h5040);
        wr(3'd5, 8'h01);
        waitc(4 * P);
        rd(3'd0, a);
        rd(3'd1, b);
        check("R6 high byte follows run 1", {ovf, b, a}, {2'b00, 8'h00, 8'h07});

        // R7 unit 1 counts without run 1 while unit 0 split, no flag
        wr(3'd4, 8'h13);
        rd(3'd2, a);
        waitc(5 * P);
        rd(3'd2, b);
        check("R7 unit 1 free-running", 8'(b - a), 5);
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFE);
        waitc(3 * P);
        rd(3'd2, a);
        rd(3'd3, b);
        check("R7 unit 1 wrap sets no flag", {ovf[1], b, a}, {1'b0, 16'h0001});

        // R8 pin counting
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h05);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd5, 8'h01);
        waitc(5 * P);
        rd(3'd0, a);
        check("R8 static low pin", a, 0);
        for (int n = 1; n <= 6; n++) begin
            ext_cnt[0] = 1'b1;
            waitc(2 * P);
            ext_cnt[0] = 1'b0;
            waitc(2 * P);
            rd(3'd0, a);
            check("R8 pulse count", a, n);
        end
        ext_cnt[0] = 1'b1;
        waitc(5 * P);
        rd(3'd0, a);
        check("R8 static high pin", a, 6);
        ext_cnt[0] = 1'b0;
        waitc(2 * P);

        // R9 gate
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h09);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h01);
        waitc(5 * P);
        rd(3'd0, a);
        check("R9 gate low blocks", a, 0);
        ext_gate[0] = 1'b1;
        waitc(5 * P);
        rd(3'd0, a);
        check("R9 gate high counts", a, 5);
        wr(3'd4, 8'h01);
        ext_gate[0] = 1'b0;
        rd(3'd0, a);
        waitc(4 * P);
        rd(3'd0, b);
        check("R9 gate pin ignored when disabled", 8'(b - a), 4);

        // R11 write priority across every prescaler phase
        for (int j = 0; j < P + 2; j++) begin
            wr(3'd0, 8'(8'h80 + j));
            rd(3'd0, c);
            check("R11 write wins", c, 8'h80 + j);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule